// File: doc/BRIEF.md
# Byte/Word Switchable Read-Only Memory

This block models a read-only memory that a host reads either as 16-bit words or as 8-bit bytes. A mode input picks the organisation. In word mode the full 16-bit word at the applied address appears on the data bus. In byte mode the most significant data pin stops being an output. It is sampled as an extra low-order address bit that picks one half of the stored word, and that half is returned on the low eight data bits.

The outputs are registered, so a read costs one clock cycle. Each data bit is presented as a value together with its own drive enable. This lets a surrounding pad ring or a bench see exactly which bits are floating. The contents come from a fixed formula held inside the block. The number of words actually stored is a parameter, and upper address bits beyond that depth wrap.

Top module: `dual_width_rom`

## Requirements
- R1: While reset is asserted, and at the first sample after it, every drive enable is 0 and every data bit is 0.
- R2: The data and drive enables seen after a rising clock edge reflect the inputs sampled at that edge. The latency is exactly one cycle, and a new read can be started every cycle.
- R3: When `ce_n` is 1, all 16 drive enables are 0, whatever `oe_n`, `word_mode`, the address or `dq15_in` are.
- R4: When `ce_n` is 0 and `oe_n` is 1, all 16 drive enables are 0.
- R5: With `ce_n`=0, `oe_n`=0 and `word_mode`=1, `dq_oe` is 16'hFFFF and `dq_o` equals the stored word at the address.
- R6: With `ce_n`=0, `oe_n`=0 and `word_mode`=0, `dq_oe` is 16'h00FF. Bits 14..8 float, and bit 15 is not driven because the pin is an input.
- R7: In byte mode, `dq15_in`=0 places bits 7..0 of the stored word on `dq_o[7:0]`, and `dq15_in`=1 places bits 15..8 of the stored word there.
- R8: Any data bit whose drive enable is 0 carries value 0 on `dq_o`.
- R9: The stored word at address a is ((a mod 2^STORE_AW) * 40503 + 23235) mod 65536. Address bits at and above STORE_AW have no effect.
- R10: In word mode `dq15_in` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (22) | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 = 16-bit words, 0 = bytes |
| dq15_in | input | 1 | Value on the top data pin, used as the byte select in byte mode |
| dq_o | output | 16 | Data value per bit |
| dq_oe | output | 16 | Drive enable per bit, 1 = driven |

## Verification
The bench builds the block with ADDR_W at its full 22 bits and STORE_AW at 4, so only 16 distinct words are stored. With that depth, addresses that differ only in bits 4 and above are easy to reach, and they must return identical data, which checks the wrap rule. The small depth also lets the bench walk every stored word in both byte halves and in word mode. Each read can be followed the next cycle by a different enable or mode combination, so every transition between the drive-enable patterns is covered.

// File: rtl/rom_pkg.sv
package rom_pkg;

    localparam int DQ_W   = 16;
    localparam int LANE_W = 8;

    typedef struct packed {
        logic [DQ_W-1:0] dq;
        logic [DQ_W-1:0] oe;
    } rom_out_t;

    // Fixed content rule: multiplicative spread of the index plus an offset
    function automatic logic [DQ_W-1:0] rom_word(input int unsigned idx);
        logic [31:0] prod;
        prod = idx * 32'd40503 + 32'd23235;
        return prod[DQ_W-1:0];
    endfunction

endpackage

// File: rtl/rom_store.sv
module rom_store
    import rom_pkg::*;
#(
    parameter int STORE_AW = 8
) (
    input  logic [STORE_AW-1:0] idx,
    output logic [DQ_W-1:0]     word
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [DQ_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign mem[g] = rom_word(g);
    end

    assign word = mem[idx];

endmodule

// File: rtl/rom_lane_mux.sv
module rom_lane_mux
    import rom_pkg::*;
(
    input  logic [DQ_W-1:0] word,
    input  logic            word_mode,
    input  logic            lane_hi,
    output logic [DQ_W-1:0] data
);

    localparam int UPPER_W = DQ_W - LANE_W;

    logic [LANE_W-1:0] lane;

    always_comb begin
        lane = lane_hi ? word[DQ_W-1 -: LANE_W] : word[LANE_W-1:0];
        if (word_mode) begin
            data = word;
        end else begin
            data = {{UPPER_W{1'b0}}, lane};
        end
    end

endmodule

// File: rtl/rom_oe_ctl.sv
module rom_oe_ctl
    import rom_pkg::*;
(
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            word_mode,
    output logic [DQ_W-1:0] oe
);

    localparam int UPPER_W = DQ_W - LANE_W;

    logic active;

    always_comb begin
        active = !ce_n && !oe_n;
        if (!active) begin
            oe = '0;
        end else if (word_mode) begin
            oe = '1;
        end else begin
            oe = {{UPPER_W{1'b0}}, {LANE_W{1'b1}}};
        end
    end

endmodule

// File: rtl/dual_width_rom.sv
module dual_width_rom
    import rom_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int STORE_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic              dq15_in,
    output logic [DQ_W-1:0]   dq_o,
    output logic [DQ_W-1:0]   dq_oe
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [STORE_AW-1:0] idx;
    logic [DQ_W-1:0]     word;
    logic [DQ_W-1:0]     lane_data;
    logic [DQ_W-1:0]     lane_oe;
    rom_out_t            out_d;
    rom_out_t            out_q;

    // Upper address bits fold away through the modulo: the array wraps
    assign idx = STORE_AW'(addr % ADDR_W'(DEPTH));

    rom_store #(
        .STORE_AW(STORE_AW)
    ) i_store (
        .idx (idx),
        .word(word)
    );

    rom_lane_mux i_mux (
        .word     (word),
        .word_mode(word_mode),
        .lane_hi  (dq15_in),
        .data     (lane_data)
    );

    rom_oe_ctl i_oe (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .word_mode(word_mode),
        .oe       (lane_oe)
    );

    always_comb begin
        out_d.oe = lane_oe;
        out_d.dq = lane_data & lane_oe;   // floating bits read as zero
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dq_o  = out_q.dq;
    assign dq_oe = out_q.oe;

endmodule

// File: rtl/dual_width_rom_chk.sv
module dual_width_rom_chk
    import rom_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            ce_n,
    input logic            oe_n,
    input logic            word_mode,
    input logic [DQ_W-1:0] dq_o,
    input logic [DQ_W-1:0] dq_oe
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (dq_oe == '0 && dq_o == '0));

    a_r3_chip_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce_n)) |-> dq_oe == '0);

    a_r4_output_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n) && $past(oe_n)) |-> dq_oe == '0);

    a_r5_word_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n) && !$past(oe_n) && $past(word_mode))
        |-> dq_oe == '1);

    a_r6_byte_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n) && !$past(oe_n) && !$past(word_mode))
        |-> dq_oe == 16'h00FF);

    a_r8_float_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_o & ~dq_oe) == '0);

endmodule

bind dual_width_rom dual_width_rom_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .word_mode(word_mode),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe)
);

// File: tb/test_dual_width_rom.sv
`timescale 1ns/1ps
module test_dual_width_rom;

    localparam int ADDR_W   = 22;
    localparam int STORE_AW = 4;

    typedef struct {
        logic [15:0] dq;
        logic [15:0] oe;
        string       req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              word_mode = 1'b1;
    logic              dq15_in = 1'b0;
    logic [15:0]       dq_o;
    logic [15:0]       dq_oe;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    dual_width_rom #(
        .ADDR_W  (ADDR_W),
        .STORE_AW(STORE_AW)
    ) i_dual_width_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .word_mode(word_mode),
        .dq15_in  (dq15_in),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe)
    );

    // Content rule from R9
    function automatic logic [15:0] stored(input logic [ADDR_W-1:0] a);
        int unsigned i;
        logic [31:0] p;
        i = int'(a) % (1 << STORE_AW);
        p = i * 40503 + 23235;
        return p[15:0];
    endfunction

    function automatic exp_t predict(input logic [ADDR_W-1:0] a, input logic c,
                                     input logic o, input logic wm, input logic hi,
                                     input string req);
        exp_t e;
        logic [15:0] w;
        w = stored(a);
        e.req = req;
        if (c || o) begin
            e.oe = 16'h0000; e.dq = 16'h0000;
        end else if (wm) begin
            e.oe = 16'hFFFF; e.dq = w;
        end else begin
            e.oe = 16'h00FF; e.dq = {8'h00, hi ? w[15:8] : w[7:0]};
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [15:0] adq, input logic [15:0] aoe,
                         input logic [15:0] edq, input logic [15:0] eoe);
        n_checks++;
        if (adq !== edq || aoe !== eoe) begin
            n_errors++;
            $display("FAIL %s: dq=%h oe=%h expected dq=%h oe=%h", req, adq, aoe, edq, eoe);
        end
    endtask

    // Driver: apply one read at a falling edge and queue its expected result
    task automatic drive(input logic [ADDR_W-1:0] a, input logic c, input logic o,
                         input logic wm, input logic hi, input string req);
        @(negedge clk);
        addr = a; ce_n = c; oe_n = o; word_mode = wm; dq15_in = hi;
        sb.push_back(predict(a, c, o, wm, hi, req));
    endtask

    // Monitor: the result of the read queued before an edge is visible just after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, dq_o, dq_oe, e.dq, e.oe);
            end
        end
    end

    initial begin
        #40000;
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: outputs quiet during reset, even with enables active
        ce_n = 1'b0; oe_n = 1'b0; addr = 22'h5;
        repeat (3) @(posedge clk);
        #1 check("R1", dq_o, dq_oe, 16'h0000, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);
        #1 check("R1", dq_o, dq_oe, 16'h0000, 16'h0000);

        // R5 / R9: every stored word in word mode
        for (int i = 0; i < 16; i++) drive(ADDR_W'(i), 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        // R9: upper address bits wrap onto the same words
        drive(22'h3FFFF3, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        drive(22'h200010, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        drive(22'h0ABC07, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        // R10: top pin toggled in word mode changes nothing
        drive(22'h9, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        drive(22'h9, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
        // R3: chip disabled under every other combination
        drive(22'h4, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
        drive(22'h4, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        drive(22'h4, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
        // R4 / R8: output enable off, values read as zero
        drive(22'hC, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        drive(22'hC, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
        // R6 / R7: both halves of every word in byte mode
        for (int i = 0; i < 16; i++) begin
            drive(ADDR_W'(i), 1'b0, 1'b0, 1'b0, 1'b0, "R7");
            drive(ADDR_W'(i), 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        end
        // R2: mode and enables change every cycle, one read per cycle
        drive(22'h1, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
        drive(22'h2, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        drive(22'h3, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
        drive(22'hE, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        drive(22'hF, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
        drive(22'hF, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
        // R1: reset in the middle of activity
        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1", dq_o, dq_oe, 16'h0000, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule